// File: doc/BRIEF.md
# Single-Lane Floating-Point Predicate Comparator

This block compares two IEEE-754 single-precision words, A and B, under a 5-bit predicate code and returns a one-bit verdict. Two exception indications come with it: an invalid-operation flag and a denormal-operand flag. A vector unit places one copy per lane. Any packing of the verdicts into masks or full-width lane results, and any trapping on the flags, happens outside the block.

Inside, each operand is first classified: its sign, whether it is zero, subnormal, a NaN, or a signalling NaN. The pair is then reduced to exactly one of four relations: less, equal, greater or unordered. The predicate code turns that relation into the verdict and also says whether a quiet NaN counts as an invalid operation. A compatibility input restricts the code to its three low bits. All outputs are registered, so each answer appears one clock after its inputs.

Top module: `fpcmp_lane`

## Requirements
- R1: When `legacy_i` is 1, only `pred_i[2:0]` selects the predicate and `pred_i[4:3]` has no effect on any output. The result is the same as for code `{2'b00, pred_i[2:0]}` with `legacy_i` at 0.
- R2: Codes 0 to 7 give these verdicts for the relations (less, equal, greater, unordered), and a 1 in the last column marks a predicate that signals on a quiet NaN. 0: (0,1,0,0) quiet; 1: (1,0,0,0) signalling; 2: (1,1,0,0) signalling; 3: (0,0,0,1) quiet; 4: (1,0,1,1) quiet; 5: (0,1,1,1) signalling; 6: (0,0,1,1) signalling; 7: (1,1,1,0) quiet.
- R3: Codes 8 to 15 give: 8: (0,1,0,1) quiet; 9: (1,0,0,1) signalling; 10: (1,1,0,1) signalling; 11: (0,0,0,0) quiet; 12: (1,0,1,0) quiet; 13: (0,1,1,0) signalling; 14: (0,0,1,0) signalling; 15: (1,1,1,1) quiet.
- R4: Each code 16 to 31 has the same verdict table as the code 16 below it. Its quiet-NaN signalling is the opposite of that code.
- R5: A NaN has an all-ones exponent and a nonzero fraction. It is quiet when fraction bit 22 is 1 and signalling otherwise. If either operand is a NaN, the relation is unordered.
- R6: +0 and -0 are equal. Other non-NaN values are ordered by sign and then by magnitude. Any negative value is below any positive value. Among negatives, the larger magnitude is lower. Infinities and subnormals take part in this ordering.
- R7: `invalid_o` is 1 when either operand is a signalling NaN, under any code. It is also 1 when the active predicate signals and either operand is any NaN. It is 0 whenever neither operand is a NaN.
- R8: `denorm_o` is 1 exactly when at least one operand has a zero exponent and a nonzero fraction.
- R9: All three outputs are registered with one cycle of latency. A synchronous active-high `rst` forces all of them to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 32 | First operand (A), single precision |
| b_i | input | 32 | Second operand (B), single precision |
| pred_i | input | 5 | Predicate code |
| legacy_i | input | 1 | Restrict predicate to its three low bits |
| result_o | output | 1 | Predicate verdict, one cycle after inputs |
| invalid_o | output | 1 | Invalid-operation indication |
| denorm_o | output | 1 | Denormal-operand indication |

## Verification
The block holds no state beyond the output register, so a fault in classification, in the relation, or in the code mapping shows up at the ports one cycle after the operands that trigger it. The operand pairs cover every relation, and each pair is swept through all 32 codes. Because of this, a wrong bit in any truth-table position, a swapped signalling attribute, or a mishandled zero sign changes `result_o` or `invalid_o` in the first cycle it matters. Legacy-mode masking is exposed by driving codes whose high bits select a different predicate.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    // Geometry of the single-precision word
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int FP_W   = 1 + EXP_W + MAN_W;
    localparam int CODE_W = 5;
    localparam int LEG_W  = 3;

    // Relation of A to B; numeric value indexes a 4-bit truth vector
    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    // Per-operand classification
    typedef struct packed {
        logic sign;
        logic zero;
        logic subn;
        logic nan;
        logic snan;
    } fp_flags_t;

    // Registered outputs
    typedef struct packed {
        logic result;
        logic invalid;
        logic denorm;
    } cmp_out_t;

    // Code actually used after legacy restriction (R1)
    function automatic logic [CODE_W-1:0] effective_code(
        input logic [CODE_W-1:0] code,
        input logic              legacy
    );
        logic [CODE_W-1:0] keep;
        keep = CODE_W'((1 << LEG_W) - 1);
        return legacy ? (code & keep) : code;
    endfunction

    // Truth vector {un, gt, eq, lt} of the four root predicates
    function automatic logic [3:0] root_truth(input logic [1:0] sel);
        logic [3:0] t;
        unique case (sel)
            2'd0:    t = 4'b0010; // equal
            2'd1:    t = 4'b0001; // less
            2'd2:    t = 4'b0011; // less or equal
            default: t = 4'b1000; // unordered
        endcase
        return t;
    endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int MW = MAN_W,
    localparam int W    = 1 + EW + MW,
    localparam int MAGW = EW + MW
) (
    input  logic [W-1:0]    word_i,
    output fp_flags_t       flags_o,
    output logic [MAGW-1:0] mag_o
);
    logic [EW-1:0] exp_f;
    logic [MW-1:0] man_f;
    logic          exp_ones, exp_none, man_any;

    always_comb begin
        exp_f    = word_i[W-2 -: EW];
        man_f    = word_i[MW-1:0];
        exp_ones = &exp_f;
        exp_none = ~|exp_f;
        man_any  = |man_f;

        flags_o.sign = word_i[W-1];
        flags_o.zero = exp_none & ~man_any;
        flags_o.subn = exp_none & man_any;
        flags_o.nan  = exp_ones & man_any;
        flags_o.snan = exp_ones & man_any & ~man_f[MW-1];
        mag_o        = word_i[MAGW-1:0];
    end
endmodule

// File: rtl/fpcmp_relate.sv
module fpcmp_relate
    import fpcmp_pkg::*;
#(
    parameter int MAGW = EXP_W + MAN_W
) (
    input  fp_flags_t       fa_i,
    input  fp_flags_t       fb_i,
    input  logic [MAGW-1:0] ma_i,
    input  logic [MAGW-1:0] mb_i,
    output rel_e            rel_o
);
    logic mag_eq, mag_lt;

    always_comb begin
        mag_eq = (ma_i == mb_i);
        mag_lt = (ma_i <  mb_i);

        if (fa_i.nan || fb_i.nan)
            rel_o = REL_UN;
        else if (fa_i.zero && fb_i.zero)
            rel_o = REL_EQ;                     // signed zeros meet
        else if (fa_i.sign != fb_i.sign)
            rel_o = fa_i.sign ? REL_LT : REL_GT;
        else if (mag_eq)
            rel_o = REL_EQ;
        else if (mag_lt)
            rel_o = fa_i.sign ? REL_GT : REL_LT; // negatives reverse
        else
            rel_o = fa_i.sign ? REL_LT : REL_GT;
    end
endmodule

// File: rtl/fpcmp_predicate.sv
module fpcmp_predicate
    import fpcmp_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic [CW-1:0] code_i,
    input  logic          legacy_i,
    input  rel_e          rel_i,
    input  logic          nan_any_i,
    input  logic          snan_any_i,
    output logic          result_o,
    output logic          invalid_o
);
    logic [CW-1:0] eff;
    logic [3:0]    truth;
    logic          signals;

    always_comb begin
        eff   = effective_code(code_i, legacy_i);
        truth = root_truth(eff[1:0]);
        if (eff[2]) truth = ~truth;           // whole-table complement
        if (eff[3]) truth[3] = ~truth[3];     // unordered-only complement
        result_o  = truth[rel_i];
        signals   = (eff[1] ^ eff[0]) ^ eff[4];
        invalid_o = snan_any_i | (signals & nan_any_i);
    end
endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
    import fpcmp_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int MW = MAN_W,
    parameter int CW = CODE_W,
    localparam int W    = 1 + EW + MW,
    localparam int MAGW = EW + MW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic [CW-1:0] pred_i,
    input  logic          legacy_i,
    output logic          result_o,
    output logic          invalid_o,
    output logic          denorm_o
);
    logic [W-1:0]    word   [2];
    fp_flags_t       flags  [2];
    logic [MAGW-1:0] mag    [2];
    rel_e            rel;
    cmp_out_t        next_q, out_q;
    logic            res_c, inv_c;

    assign word[0] = a_i;
    assign word[1] = b_i;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fpcmp_classify #(.EW(EW), .MW(MW)) u_cls (
            .word_i  (word[i]),
            .flags_o (flags[i]),
            .mag_o   (mag[i])
        );
    end

    fpcmp_relate #(.MAGW(MAGW)) u_rel (
        .fa_i  (flags[0]),
        .fb_i  (flags[1]),
        .ma_i  (mag[0]),
        .mb_i  (mag[1]),
        .rel_o (rel)
    );

    fpcmp_predicate #(.CW(CW)) u_pred (
        .code_i     (pred_i),
        .legacy_i   (legacy_i),
        .rel_i      (rel),
        .nan_any_i  (flags[0].nan  | flags[1].nan),
        .snan_any_i (flags[0].snan | flags[1].snan),
        .result_o   (res_c),
        .invalid_o  (inv_c)
    );

    always_comb begin
        next_q.result  = res_c;
        next_q.invalid = inv_c;
        next_q.denorm  = flags[0].subn | flags[1].subn;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= next_q;
    end

    assign result_o  = out_q.result;
    assign invalid_o = out_q.invalid;
    assign denorm_o  = out_q.denorm;
endmodule

// File: rtl/fpcmp_lane_chk.sv
module fpcmp_lane_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] a_i,
    input logic [31:0] b_i,
    input logic [4:0]  pred_i,
    input logic        legacy_i,
    input logic        result_o,
    input logic        invalid_o,
    input logic        denorm_o
);
    function automatic logic is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
    endfunction
    function automatic logic is_snan(input logic [31:0] x);
        return is_nan(x) && !x[22];
    endfunction
    function automatic logic is_sub(input logic [31:0] x);
        return (x[30:23] == 8'h00) && (x[22:0] != 23'd0);
    endfunction

    assert_snan_invalid_R7: assert property (@(posedge clk) disable iff (rst)
        (is_snan(a_i) || is_snan(b_i)) |=> invalid_o);

    assert_ordered_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (!is_nan(a_i) && !is_nan(b_i)) |=> !invalid_o);

    assert_false_code_R3: assert property (@(posedge clk) disable iff (rst)
        (!legacy_i && pred_i[3:0] == 4'hB) |=> !result_o);

    assert_true_code_R3: assert property (@(posedge clk) disable iff (rst)
        (!legacy_i && pred_i[3:0] == 4'hF) |=> result_o);

    assert_unord_nan_R5: assert property (@(posedge clk) disable iff (rst)
        ((is_nan(a_i) || is_nan(b_i)) && pred_i[2:0] == 3'd3 &&
         (legacy_i || !pred_i[3])) |=> result_o);

    assert_same_word_eq_R6: assert property (@(posedge clk) disable iff (rst)
        (!is_nan(a_i) && a_i == b_i && !legacy_i && pred_i == 5'h00) |=> result_o);

    assert_denorm_set_R8: assert property (@(posedge clk) disable iff (rst)
        (is_sub(a_i) || is_sub(b_i)) |=> denorm_o);

    assert_denorm_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (!is_sub(a_i) && !is_sub(b_i)) |=> !denorm_o);

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!result_o && !invalid_o && !denorm_o));
endmodule

bind fpcmp_lane fpcmp_lane_chk u_chk (.*);

// File: tb/sim_fpcmp_lane.sv
`timescale 1ns/1ps
module sim_fpcmp_lane;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] a_i, b_i;
    logic [4:0]  pred_i;
    logic        legacy_i;
    logic        result_o, invalid_o, denorm_o;

    always #4 clk = ~clk;

    fpcmp_lane u0 (
        .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .pred_i(pred_i),
        .legacy_i(legacy_i), .result_o(result_o), .invalid_o(invalid_o),
        .denorm_o(denorm_o)
    );

    // {signals, un, gt, eq, lt} for codes 0..15 (R2, R3)
    localparam logic [4:0] TT [16] = '{
        5'b00010, 5'b10001, 5'b10011, 5'b01000,
        5'b01101, 5'b11110, 5'b11100, 5'b00111,
        5'b01010, 5'b11001, 5'b11011, 5'b00000,
        5'b00101, 5'b10110, 5'b10100, 5'b01111
    };

    // {a, b, relation(0 lt,1 eq,2 gt,3 un), snan, denorm}
    localparam logic [67:0] PAIRS [14] = '{
        {32'h3F800000, 32'h40000000, 2'd0, 1'b0, 1'b0},
        {32'h40000000, 32'h3F800000, 2'd2, 1'b0, 1'b0},
        {32'h3F800000, 32'h3F800000, 2'd1, 1'b0, 1'b0},
        {32'h00000000, 32'h80000000, 2'd1, 1'b0, 1'b0},
        {32'hBF800000, 32'hC0000000, 2'd2, 1'b0, 1'b0},
        {32'hBF800000, 32'h3F800000, 2'd0, 1'b0, 1'b0},
        {32'h7FC00000, 32'h3F800000, 2'd3, 1'b0, 1'b0},
        {32'h3F800000, 32'h7F800001, 2'd3, 1'b1, 1'b0},
        {32'h7F800000, 32'h3F800000, 2'd2, 1'b0, 1'b0},
        {32'hFF800000, 32'h80000000, 2'd0, 1'b0, 1'b0},
        {32'h00000001, 32'h00000000, 2'd2, 1'b0, 1'b1},
        {32'h80000001, 32'h00000001, 2'd0, 1'b0, 1'b1},
        {32'hFFC00000, 32'h7FC00000, 2'd3, 1'b0, 1'b0},
        {32'h7F800001, 32'h00400000, 2'd3, 1'b1, 1'b1}
    };

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    function automatic logic [4:0] entry(input int code);
        return (code < 16) ? TT[code] : (TT[code-16] ^ 5'b10000);   // R4
    endfunction

    task automatic check(input string req, input logic act, input logic exp,
                         input int pair, input int code);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pair %0d code %0d: actual %0b expected %0b",
                     req, pair, code, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] p, input logic leg);
        @(negedge clk);
        a_i = a; b_i = b; pred_i = p; legacy_i = leg;
        @(negedge clk);   // registered: output valid one edge later
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; a_i = 32'h3F800000; b_i = 32'h3F800000;
        pred_i = 5'h0F; legacy_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R9", result_o, 1'b0, -1, 15);
        check("R9", invalid_o, 1'b0, -1, 15);
        check("R9", denorm_o, 1'b0, -1, 15);
        rst = 1'b0;

        // Full sweep: every pair under every code
        foreach (PAIRS[p]) begin
            for (int c = 0; c < 32; c++) begin
                logic [31:0] a, b;
                logic [1:0]  rel;
                logic        sn, dn;
                logic [4:0]  e;
                string       tag;
                {a, b, rel, sn, dn} = PAIRS[p];
                e = entry(c);
                tag = (c < 8) ? "R2" : ((c < 16) ? "R3" : "R4");
                drive(a, b, 5'(c), 1'b0);
                check(tag, result_o, e[rel], p, c);
                check("R7", invalid_o, sn | (e[4] & (rel == 2'd3)), p, c);
                check("R8", denorm_o, dn, p, c);
            end
        end

        // Legacy restriction: high code bits must not matter (R1)
        foreach (PAIRS[p]) begin
            for (int c = 8; c < 32; c += 5) begin
                logic [31:0] a, b;
                logic [1:0]  rel;
                logic        sn, dn;
                logic [4:0]  e;
                {a, b, rel, sn, dn} = PAIRS[p];
                e = entry(c & 7);
                drive(a, b, 5'(c), 1'b1);
                check("R1", result_o, e[rel], p, c);
                check("R1", invalid_o, sn | (e[4] & (rel == 2'd3)), p, c);
            end
        end

        // Directed corner cases
        drive(32'h7FC00000, 32'h7FC00000, 5'h03, 1'b0);
        check("R5", result_o, 1'b1, -1, 3);
        drive(32'h7FA00000, 32'h3F800000, 5'h07, 1'b0);   // sNaN, quiet ORD
        check("R5", result_o, 1'b0, -1, 7);
        check("R7", invalid_o, 1'b1, -1, 7);
        drive(32'h7FC00000, 32'h3F800000, 5'h00, 1'b0);   // qNaN, quiet EQ
        check("R7", invalid_o, 1'b0, -1, 0);
        drive(32'h80000000, 32'h00000000, 5'h00, 1'b0);
        check("R6", result_o, 1'b1, -1, 0);
        drive(32'h80000000, 32'h00000000, 5'h01, 1'b0);
        check("R6", result_o, 1'b0, -1, 1);
        drive(32'hC0400000, 32'hC0000000, 5'h01, 1'b0);   // -3 < -2
        check("R6", result_o, 1'b1, -1, 1);
        drive(32'h00000001, 32'h80000000, 5'h0E, 1'b0);   // tiny > -0
        check("R6", result_o, 1'b1, -1, 14);
        check("R8", denorm_o, 1'b1, -1, 14);

        // Mid-run reset clears outputs (R9)
        drive(32'h7F800001, 32'h00000001, 5'h0F, 1'b0);
        check("R9", result_o, 1'b1, -1, 15);
        rst = 1'b1;
        @(negedge clk);
        check("R9", result_o, 1'b0, -1, 15);
        check("R9", invalid_o, 1'b0, -1, 15);
        check("R9", denorm_o, 1'b0, -1, 15);
        rst = 1'b0;
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule